// File: doc/BRIEF.md
# Real-Time Clock Time and Calendar Update Engine

This block holds the seven time and calendar fields of a real-time clock: seconds, minutes, hours, day of week, date, month and a two-digit year. On every one-cycle pulse of a 1 Hz tick it advances them by one second. The seconds carry into minutes, minutes into hours, and hours into a day advance. A day advance steps the weekday and the date, and the date rolls over according to the length of the current month.

A control register picks the field encoding, either BCD or plain binary. It also picks 12-hour or 24-hour hour format and turns the daylight-saving jumps on or off. Its hold bit suppresses updates, so software can load a consistent time through the write port. Any field can be read back through a combinational read port. Every update that actually happens is followed by a one-cycle done pulse.

A write cycle takes precedence over the update logic: a tick that arrives in the same cycle as a write is dropped.

Top module: `rtc_calendar_engine`

## Requirements
- R1: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year and 7 control. After reset they read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 and 0x04 (24-hour, BCD, no hold, no daylight saving).
- R2: While control bit 0 (hold) is 1, ticks change no time or calendar field and produce no done pulse.
- R3: A tick with hold at 0 and no write in the same cycle updates the fields at the next clock edge. `upd_done` is high for exactly the one cycle in which the new values first appear.
- R4: Seconds and minutes wrap 59 to 0 with a carry. Hours wrap 23 to 0 in 24-hour mode, and that wrap advances the day.
- R5: Control bit 1 selects binary encoding (1) or BCD encoding (0) for every field on both the write and the read side.
- R6: Control bit 2 selects 24-hour (1) or 12-hour (0) mode. In 12-hour mode, hours bit 7 is the PM flag and bits 6:0 count 12, 1 to 11. The flag toggles when 11:59:59 steps to 12:00:00, and 11:59:59 PM steps to 12:00:00 AM with a day advance.
- R7: The weekday counts 1 to 7 (1 is Sunday) and steps from 7 back to 1 on a day advance.
- R8: The date rolls over to 1 after day 30 in April, June, September and November, and after day 31 in the other months. February has 29 days when the year is a multiple of 4 and 28 otherwise.
- R9: Month 12 rolls over to 1 and increments the year, and year 99 rolls over to 0.
- R10: With control bit 3 (daylight saving) at 1, on a Sunday in April with date 1 to 7, the time 1:59:59 AM is followed by 3:00:00 AM.
- R11: With daylight saving at 1, on a Sunday in October with date 25 or later, the first arrival at 1:59:59 AM is followed by 1:00:00 AM. The second arrival on that day proceeds to 2:00:00, and other October Sundays are not affected.
- R12: With daylight saving at 0, neither jump occurs and 1:59:59 steps to 2:00:00 in April and October.
- R13: The update logic never changes the control register; only a write to address 7 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | 8 | Combinational read data |
| upd_done | output | 1 | One-cycle pulse after each completed update |

## Verification
The bench sweeps across full hours, in both encodings and both hour formats. A wrong BCD digit carry shows up at x9 seconds, and a misplaced PM toggle turns noon or midnight into the wrong half of the day.

Every month is driven to its last day in a leap year and in a common year. An off-by-one month table would roll a 30-day month on day 31, or let February reach 29 in a common year.

For daylight saving, a fall-back without a remembered flag would loop back forever at 1:59:59 in October. The bench therefore replays the whole repeated hour. It also checks that hold really freezes the seconds and suppresses the done pulse.

// File: rtl/rtc_calendar_engine.sv
`timescale 1ns/1ps
module rtc_calendar_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       upd_done
);
  localparam logic [2:0] A_SEC = 3'd0, A_MIN = 3'd1, A_HOUR = 3'd2, A_DOW = 3'd3,
                         A_DATE = 3'd4, A_MON = 3'd5, A_YEAR = 3'd6, A_CTL = 3'd7;
  localparam logic [3:0] CTL_RST = 4'b0100;

  logic [7:0] sec_r, min_r, hour_r, dow_r, date_r, mon_r, year_r;
  logic [3:0] ctl_r;
  logic       fell_r;

  logic hold, bin, hr24, dst, upd;
  assign hold = ctl_r[0];
  assign bin  = ctl_r[1];
  assign hr24 = ctl_r[2];
  assign dst  = ctl_r[3];
  assign upd  = tick_1hz & ~hold & ~wr_en;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic b);
    return b ? v[6:0] : (7'(v[7:4]) * 7'd10 + 7'(v[3:0]));
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] n, input logic b);
    logic [6:0] q;
    q = n / 7'd10;
    return b ? {1'b0, n} : {q[3:0], 4'(n % 7'd10)};
  endfunction

  logic [6:0] s, m, h, h12raw, dw, d, mo, y, dim;
  logic [6:0] ns, nm, nh, ndw, nd, nmo, ny, nh12;
  logic       day_adv, at_159, spring, fall;
  logic [7:0] hbits, hour_next;

  assign s      = dec(sec_r, bin);
  assign m      = dec(min_r, bin);
  assign h12raw = dec({1'b0, hour_r[6:0]}, bin);
  assign h      = hr24 ? dec(hour_r, bin)
                       : ((h12raw == 7'd12 ? 7'd0 : h12raw) + (hour_r[7] ? 7'd12 : 7'd0));
  assign dw     = dow_r[6:0];
  assign d      = dec(date_r, bin);
  assign mo     = dec(mon_r, bin);
  assign y      = dec(year_r, bin);

  assign dim = (mo == 7'd2) ? ((y[1:0] == 2'd0) ? 7'd29 : 7'd28)
             : (mo == 7'd4 || mo == 7'd6 || mo == 7'd9 || mo == 7'd11) ? 7'd30 : 7'd31;

  assign at_159 = (h == 7'd1) && (m == 7'd59) && (s == 7'd59);
  assign spring = dst && at_159 && (mo == 7'd4) && (dw == 7'd1) && (d <= 7'd7);
  assign fall   = dst && at_159 && (mo == 7'd10) && (dw == 7'd1) && (d >= 7'd25) && !fell_r;

  always_comb begin
    ns = s + 7'd1; nm = m; nh = h; ndw = dw; nd = d; nmo = mo; ny = y;
    day_adv = 1'b0;
    if (s >= 7'd59) begin
      ns = 7'd0;
      nm = m + 7'd1;
      if (m >= 7'd59) begin
        nm = 7'd0;
        nh = h + 7'd1;
        if (h >= 7'd23) begin
          nh = 7'd0;
          day_adv = 1'b1;
        end
      end
    end
    if (spring) nh = 7'd3;
    if (fall)   nh = 7'd1;
    if (day_adv) begin
      ndw = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
      if (d >= dim) begin
        nd = 7'd1;
        if (mo >= 7'd12) begin
          nmo = 7'd1;
          ny  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
        end else begin
          nmo = mo + 7'd1;
        end
      end else begin
        nd = d + 7'd1;
      end
    end
  end

  assign nh12      = (nh == 7'd0) ? 7'd12 : (nh > 7'd12 ? nh - 7'd12 : nh);
  assign hbits     = enc(nh12, bin);
  assign hour_next = hr24 ? enc(nh, bin) : {(nh >= 7'd12), hbits[6:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_r    <= 8'h00;
      min_r    <= 8'h00;
      hour_r   <= 8'h00;
      dow_r    <= 8'h01;
      date_r   <= 8'h01;
      mon_r    <= 8'h01;
      year_r   <= 8'h00;
      ctl_r    <= CTL_RST;
      fell_r   <= 1'b0;
      upd_done <= 1'b0;
    end else begin
      upd_done <= upd;
      if (wr_en) begin
        case (wr_addr)
          A_SEC:   sec_r  <= wr_data;
          A_MIN:   min_r  <= wr_data;
          A_HOUR:  hour_r <= wr_data;
          A_DOW:   dow_r  <= wr_data;
          A_DATE:  date_r <= wr_data;
          A_MON:   mon_r  <= wr_data;
          A_YEAR:  year_r <= wr_data;
          default: ctl_r  <= wr_data[3:0];
        endcase
      end else if (upd) begin
        sec_r  <= enc(ns, bin);
        min_r  <= enc(nm, bin);
        hour_r <= hour_next;
        dow_r  <= {1'b0, ndw};
        date_r <= enc(nd, bin);
        mon_r  <= enc(nmo, bin);
        year_r <= enc(ny, bin);
        if (fall)         fell_r <= 1'b1;
        else if (day_adv) fell_r <= 1'b0;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = sec_r;
      A_MIN:   rd_data = min_r;
      A_HOUR:  rd_data = hour_r;
      A_DOW:   rd_data = dow_r;
      A_DATE:  rd_data = date_r;
      A_MON:   rd_data = mon_r;
      A_YEAR:  rd_data = year_r;
      default: rd_data = {4'b0000, ctl_r};
    endcase
  end
endmodule

// File: rtl/rtc_calendar_checker.sv
`timescale 1ns/1ps
module rtc_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic       upd_done,
  input logic [3:0] ctl,
  input logic [7:0] sec,
  input logic [7:0] dow
);
  assert_hold_freezes_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && !wr_en) |=> $stable(sec));

  assert_hold_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[0] |=> !upd_done);

  assert_done_follows_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(tick));

  assert_ctl_untouched_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl));

  assert_dow_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && $past(dow) >= 8'd1 && $past(dow) <= 8'd6)
      |-> (dow == $past(dow) || dow == $past(dow) + 8'd1));
endmodule

bind rtc_calendar_engine rtc_calendar_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(wr_en), .upd_done(upd_done),
  .ctl(ctl_r), .sec(sec_r), .dow(dow_r)
);

// File: tb/sim_rtc_calendar_engine.sv
`timescale 1ns/1ps
module sim_rtc_calendar_engine;
  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0, rd_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic upd_done;
  int errors = 0, checks = 0;
  logic [3:0] ctl = 4'b0100;

  always #10 clk = ~clk;

  rtc_calendar_engine u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .upd_done(upd_done)
  );

  function automatic logic [7:0] e(input int n, input bit b);
    return b ? 8'(n) : 8'((n / 10) * 16 + n % 10);
  endfunction

  function automatic logic [7:0] eh(input int hr, input bit b, input bit h24);
    int h12;
    logic [7:0] t;
    if (h24) return e(hr, b);
    h12 = (hr % 12 == 0) ? 12 : hr % 12;
    t = e(h12, b);
    return {(hr >= 12) ? 1'b1 : 1'b0, t[6:0]};
  endfunction

  function automatic int dim_of(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.2;
    d = rd_data;
  endtask

  task automatic step(output logic done);
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    done = upd_done;
  endtask

  task automatic set_time(input int t);
    wr(3'd7, {4'b0000, ctl | 4'b0001});
    wr(3'd0, e(t % 60, ctl[1]));
    wr(3'd1, e((t / 60) % 60, ctl[1]));
    wr(3'd2, eh(t / 3600, ctl[1], ctl[2]));
    wr(3'd7, {4'b0000, ctl});
  endtask

  task automatic set_date(input int dw, input int d, input int mo, input int y);
    wr(3'd7, {4'b0000, ctl | 4'b0001});
    wr(3'd3, 8'(dw));
    wr(3'd4, e(d, ctl[1]));
    wr(3'd5, e(mo, ctl[1]));
    wr(3'd6, e(y, ctl[1]));
    wr(3'd7, {4'b0000, ctl});
  endtask

  task automatic read_time(output logic [23:0] v);
    logic [7:0] hh, mm, ss;
    rd(3'd2, hh); rd(3'd1, mm); rd(3'd0, ss);
    v = {hh, mm, ss};
  endtask

  function automatic logic [23:0] exp_time(input int t);
    int tt;
    tt = t % 86400;
    return {eh(tt / 3600, ctl[1], ctl[2]), e((tt / 60) % 60, ctl[1]), e(tt % 60, ctl[1])};
  endfunction

  task automatic sweep(input int t0, input int n, input string tag);
    logic dn;
    logic [23:0] v;
    set_time(t0);
    for (int i = 1; i <= n; i++) begin
      step(dn);
      read_time(v);
      chk(32'(v), 32'(exp_time(t0 + i)), tag);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic dn;
    logic [7:0] r;
    logic [23:0] v;
    logic [7:0] rst_exp [8];
    rst_exp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h04};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      chk(32'(r), 32'(rst_exp[a]), "R1 reset value");
    end

    // R3 done pulse width and timing
    step(dn);
    chk(32'(dn), 32'd1, "R3 done pulse");
    rd(3'd0, r);
    chk(32'(r), 32'h01, "R3 seconds updated");
    @(negedge clk);
    chk(32'(upd_done), 32'd0, "R3 pulse one cycle");

    // R2 hold
    wr(3'd7, 8'h05);
    for (int i = 0; i < 3; i++) begin
      step(dn);
      chk(32'(dn), 32'd0, "R2 no done under hold");
      rd(3'd0, r);
      chk(32'(r), 32'h01, "R2 seconds frozen");
    end
    rd(3'd7, r);
    chk(32'(r), 32'h05, "R13 control kept");
    wr(3'd7, 8'h04);

    // R4/R5 binary and BCD sweeps across an hour and midnight
    ctl = 4'b0110;
    set_date(3, 15, 6, 21);
    sweep(22 * 3600 + 59 * 60, 3660, "R4 binary 24h");
    rd(3'd3, r); chk(32'(r), 32'd4, "R7 weekday after midnight");
    rd(3'd4, r); chk(32'(r), 32'd16, "R4 date after midnight");
    ctl = 4'b0100;
    set_date(3, 15, 6, 21);
    sweep(22 * 3600 + 59 * 60, 3660, "R5 BCD 24h");
    rd(3'd4, r); chk(32'(r), 32'h16, "R5 BCD date");

    // R6 12-hour mode
    ctl = 4'b0000;
    sweep(11 * 3600 + 59 * 60, 120, "R6 noon BCD");
    sweep(12 * 3600 + 59 * 60, 120, "R6 one PM BCD");
    set_date(2, 9, 5, 22);
    sweep(23 * 3600 + 59 * 60, 120, "R6 midnight BCD");
    rd(3'd4, r); chk(32'(r), 32'h10, "R6 day advance at 12 AM");
    ctl = 4'b0010;
    sweep(11 * 3600 + 59 * 60, 120, "R6 noon binary");
    sweep(23 * 3600 + 59 * 60, 120, "R6 midnight binary");

    // R7 weekday wrap
    ctl = 4'b0100;
    set_date(7, 10, 3, 22);
    set_time(86399);
    step(dn);
    rd(3'd3, r); chk(32'(r), 32'd1, "R7 weekday 7 to 1");

    // R8/R9 month lengths, leap and common years
    for (int yi = 0; yi < 2; yi++) begin
      int y;
      y = (yi == 0) ? 23 : 24;
      for (int mo = 1; mo <= 12; mo++) begin
        int dm;
        dm = dim_of(mo, y);
        set_date(2, dm - 1, mo, y);
        set_time(86399);
        step(dn);
        rd(3'd4, r); chk(32'(r), 32'(e(dm, 1'b0)), "R8 no early rollover");
        set_time(86399);
        step(dn);
        rd(3'd4, r); chk(32'(r), 32'h01, "R8 date rollover");
        rd(3'd5, r); chk(32'(r), 32'(e(mo == 12 ? 1 : mo + 1, 1'b0)), "R8 month advance");
        rd(3'd6, r); chk(32'(r), 32'(e(mo == 12 ? y + 1 : y, 1'b0)), "R9 year");
      end
    end
    set_date(1, 31, 12, 99);
    set_time(86399);
    step(dn);
    rd(3'd6, r); chk(32'(r), 32'h00, "R9 year 99 to 0");
    rd(3'd5, r); chk(32'(r), 32'h01, "R9 month 12 to 1");

    // R12 daylight saving disabled
    set_date(1, 3, 4, 22);
    set_time(7199);
    step(dn);
    read_time(v); chk(32'(v), 32'(exp_time(7200)), "R12 April no jump");
    set_date(1, 27, 10, 22);
    set_time(7199);
    step(dn);
    read_time(v); chk(32'(v), 32'(exp_time(7200)), "R12 October no jump");

    // R10 spring forward
    ctl = 4'b1100;
    set_date(1, 3, 4, 22);
    set_time(7199);
    step(dn);
    read_time(v); chk(32'(v), 32'(exp_time(3 * 3600)), "R10 spring forward");
    set_date(1, 10, 4, 22);
    set_time(7199);
    step(dn);
    read_time(v); chk(32'(v), 32'(exp_time(7200)), "R10 second Sunday untouched");

    // R11 fall back once
    set_date(1, 20, 10, 22);
    set_time(7199);
    step(dn);
    read_time(v); chk(32'(v), 32'(exp_time(7200)), "R11 earlier Sunday untouched");
    set_date(1, 27, 10, 22);
    set_time(7199);
    step(dn);
    read_time(v); chk(32'(v), 32'(exp_time(3600)), "R11 fall back");
    sweep(3600, 3599, "R11 repeated hour");
    step(dn);
    read_time(v); chk(32'(v), 32'(exp_time(7200)), "R11 no second fall back");

    rd(3'd7, r);
    chk(32'(r), 32'h0C, "R13 control after updates");

    finish_run();
  end
endmodule